// File: doc/BRIEF.md
# Configuration Register Command Decoder

This block sits behind a host control channel and turns short byte-wide command packets into writes and reads of a small register file. The host presents one byte per cycle with a valid strobe and marks the final byte of each packet with a boundary flag. The decoded register values drive a 16-bit channel enable mask, a sample clock base selection and a sample rate divider.

There are two packet kinds. A write packet has four bytes: header 0x80, sub-code 0x01, register address, then data. A read packet has three bytes: header 0x81, sub-code 0x01, then the register address. A read is answered one cycle later with a single response byte.

The parser is a state machine with these states: IDLE (waiting for a header), WR_SUB, WR_ADDR and WR_DATA (inside a write), RD_SUB and RD_ADDR (inside a read), and DROP (skipping a malformed packet until its boundary byte).

The transitions are as follows:
- A header byte moves the machine from IDLE to WR_SUB or RD_SUB. Any other non-final byte in IDLE moves it to DROP.
- A sub-code of 0x01 advances the machine to WR_ADDR or RD_ADDR.
- A non-final address byte moves it from WR_ADDR to WR_DATA.
- A final byte in WR_DATA commits the write. A final byte in RD_ADDR issues the read.
- Any final byte returns the machine to IDLE.
- A non-final byte where a final byte was required, or a wrong header or sub-code, moves the machine to DROP.

Top module: `cfgdec_top`

## Requirements
- R1: After reset the channel mask, clock base and rate divider are all zero, and no response is presented.
- R2: A write packet of exactly four valid bytes 0x80, 0x01, address, data, with the boundary flag set on the fourth byte only, stores the data. The new value is visible on the outputs in the cycle after the fourth byte is accepted.
- R3: Address 0x02 drives channel mask bits 7:0 and address 0x03 drives channel mask bits 15:8.
- R4: Address 0x0a drives the clock base selection output and address 0x04 drives the rate divider output.
- R5: A read packet of exactly three valid bytes 0x81, 0x01, address, with the boundary flag on the third byte only, produces a response. The response valid flag is high for exactly one cycle, the cycle after the third byte, and the response byte equals the register value.
- R6: A read of any address other than 0x02, 0x03, 0x04 or 0x0a returns 0x00.
- R7: A packet whose first byte is neither 0x80 nor 0x81 changes no register and produces no response.
- R8: A packet that ends, by boundary flag, before its full length changes no register and produces no response.
- R9: A packet that runs past its full length without a boundary flag changes no register and produces no response.
- R10: A packet whose second byte is not 0x01 changes no register and produces no response.
- R11: A well-formed write to an unmapped address changes no register.
- R12: After any discarded packet, the next packet is decoded normally, starting from its first byte.
- R13: Cycles with the valid strobe low are ignored, whatever the byte and boundary inputs hold, so bytes of one packet may be separated by idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte valid strobe |
| in_byte | input | 8 | Command byte |
| in_last | input | 1 | Marks the final byte of a packet |
| rsp_valid | output | 1 | Read response valid, one-cycle pulse |
| rsp_byte | output | 8 | Read response data |
| chan_mask | output | 16 | Channel enable mask, one bit per probe |
| clk_base | output | 8 | Sample clock base selection |
| rate_div | output | 8 | Sample rate divider |

## Verification
The assertions assume that every packet ends with a byte carrying the boundary flag. They also assume that the boundary and byte inputs only matter while the valid strobe is high. Under those assumptions, a response cannot follow another in the next cycle, and the outputs can change only at a boundary byte. The bench drives every packet through a task that sets the boundary flag on exactly the byte it intends. It deliberately places garbage on the byte and boundary inputs during idle gaps, to show that they are ignored.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 4;

    localparam logic [BYTE_W-1:0] HDR_WRITE = 8'h80;
    localparam logic [BYTE_W-1:0] HDR_READ  = 8'h81;
    localparam logic [BYTE_W-1:0] SUB_CODE  = 8'h01;

    // Register slots: 0 mask low, 1 mask high, 2 divider, 3 clock base
    localparam int SLOT_MASK_LO = 0;
    localparam int SLOT_MASK_HI = 1;
    localparam int SLOT_DIV     = 2;
    localparam int SLOT_BASE    = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_SUB,
        S_WR_ADDR,
        S_WR_DATA,
        S_RD_SUB,
        S_RD_ADDR,
        S_DROP
    } state_e;

    function automatic logic [BYTE_W-1:0] slot_addr(input int slot);
        case (slot)
            SLOT_MASK_LO: slot_addr = 8'h02;
            SLOT_MASK_HI: slot_addr = 8'h03;
            SLOT_DIV:     slot_addr = 8'h04;
            default:      slot_addr = 8'h0a;
        endcase
    endfunction

endpackage

// File: rtl/cfgdec_parser.sv
module cfgdec_parser
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    output logic              wr_en,
    output logic              rd_en,
    output logic [BYTE_W-1:0] op_addr,
    output logic [BYTE_W-1:0] op_data,
    output state_e            state_q
);

    state_e            state_d;
    logic [BYTE_W-1:0] addr_q;

    // state register and captured write address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid && state_q == S_WR_ADDR) begin
                addr_q <= in_byte;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (in_valid) begin
            unique case (state_q)
                S_IDLE: begin
                    if (in_last)                  state_d = S_IDLE;
                    else if (in_byte == HDR_WRITE) state_d = S_WR_SUB;
                    else if (in_byte == HDR_READ)  state_d = S_RD_SUB;
                    else                           state_d = S_DROP;
                end
                S_WR_SUB: begin
                    if (in_last)                  state_d = S_IDLE;
                    else if (in_byte == SUB_CODE) state_d = S_WR_ADDR;
                    else                          state_d = S_DROP;
                end
                S_WR_ADDR: begin
                    if (in_last) state_d = S_IDLE;
                    else         state_d = S_WR_DATA;
                end
                S_WR_DATA: begin
                    if (in_last) state_d = S_IDLE;
                    else         state_d = S_DROP;
                end
                S_RD_SUB: begin
                    if (in_last)                  state_d = S_IDLE;
                    else if (in_byte == SUB_CODE) state_d = S_RD_ADDR;
                    else                          state_d = S_DROP;
                end
                S_RD_ADDR: begin
                    if (in_last) state_d = S_IDLE;
                    else         state_d = S_DROP;
                end
                S_DROP: begin
                    if (in_last) state_d = S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // operation strobes
    always_comb begin
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        op_addr = addr_q;
        op_data = in_byte;
        unique case (state_q)
            S_WR_DATA: wr_en = in_valid && in_last;
            S_RD_ADDR: begin
                rd_en   = in_valid && in_last;
                op_addr = in_byte;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfgdec_regfile.sv
module cfgdec_regfile
    import cfgdec_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [BYTE_W-1:0]              op_addr,
    input  logic [BYTE_W-1:0]              op_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] reg_vals,
    output logic                           rsp_valid,
    output logic [BYTE_W-1:0]              rsp_byte
);

    logic [BYTE_W-1:0] rd_value;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam logic [BYTE_W-1:0] ADDR = slot_addr(g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_vals[g] <= '0;
            end else if (wr_en && op_addr == ADDR) begin
                reg_vals[g] <= op_data;
            end
        end
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (op_addr == slot_addr(i)) rd_value = reg_vals[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_byte <= rd_value;
        end
    end

endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
    import cfgdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        in_last,
    output logic        rsp_valid,
    output logic [7:0]  rsp_byte,
    output logic [15:0] chan_mask,
    output logic [7:0]  clk_base,
    output logic [7:0]  rate_div
);

    logic                            wr_en;
    logic                            rd_en;
    logic [BYTE_W-1:0]               op_addr;
    logic [BYTE_W-1:0]               op_data;
    logic [NUM_REGS-1:0][BYTE_W-1:0] reg_vals;
    state_e                          parse_state;

    cfgdec_parser u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_last  (in_last),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .state_q  (parse_state)
    );

    cfgdec_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .reg_vals  (reg_vals),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte)
    );

    assign chan_mask = {reg_vals[SLOT_MASK_HI], reg_vals[SLOT_MASK_LO]};
    assign rate_div  = reg_vals[SLOT_DIV];
    assign clk_base  = reg_vals[SLOT_BASE];

endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker
    import cfgdec_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_last,
    input logic        rsp_valid,
    input logic [15:0] chan_mask,
    input logic [7:0]  clk_base,
    input logic [7:0]  rate_div,
    input state_e      state_q
);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_rsp_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(in_valid && in_last));

    a_r7_rsp_only_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(state_q == S_RD_ADDR));

    a_r2_change_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> ($stable(chan_mask) && $stable(clk_base) && $stable(rate_div)));

    a_r12_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> state_q == S_IDLE);

    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state_q));

endmodule

bind cfgdec_top cfgdec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .rsp_valid (rsp_valid),
    .chan_mask (chan_mask),
    .clk_base  (clk_base),
    .rate_div  (rate_div),
    .state_q   (parse_state)
);

// File: tb/tb_cfgdec_top.sv
module tb_cfgdec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_last = 1'b0;
    logic        rsp_valid;
    logic [7:0]  rsp_byte;
    logic [15:0] chan_mask;
    logic [7:0]  clk_base;
    logic [7:0]  rate_div;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // model of the register file
    logic [7:0] m_lo = 0, m_hi = 0, m_div = 0, m_base = 0;

    always #2 clk = ~clk;   // 250 MHz

    cfgdec_top dut (.*);

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h02:   return m_lo;
            8'h03:   return m_hi;
            8'h04:   return m_div;
            8'h0a:   return m_base;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        in_last  = last;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hA5;   // garbage while idle
            in_last  = 1'b1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        put(8'h80, 0); put(8'h01, 0); put(a, 0); put(d, 1);
        case (a)
            8'h02: m_lo = d;
            8'h03: m_hi = d;
            8'h04: m_div = d;
            8'h0a: m_base = d;
            default: ;
        endcase
        idle(1);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        put(8'h81, 0); put(8'h01, 0); put(a, 1);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        idle(2);
    endtask

    task automatic check_regs(input string tag);
        check({tag, " mask"}, chan_mask, {m_hi, m_lo});
        check({tag, " div"},  rate_div, m_div);
        check({tag, " base"}, clk_base, m_base);
    endtask

    // monitor / scoreboard
    logic prev_rsp = 0;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (prev_rsp) check("R5 pulse width", 1, 0);
            if (exp_q.size() == 0) begin
                check("R7 unexpected response", 1, 0);
            end else begin
                check(tag_q.pop_front(), rsp_byte, exp_q.pop_front());
            end
        end
        prev_rsp = rsp_valid;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset mask", chan_mask, 16'h0);
        check("R1 reset div", rate_div, 8'h0);
        check("R1 reset base", clk_base, 8'h0);
        check("R1 reset rsp", rsp_valid, 0);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 channel mask patterns
        wr(8'h02, 8'h07); wr(8'h03, 8'h00); check_regs("R3 three");
        wr(8'h02, 8'h3f); check_regs("R3 six");
        wr(8'h02, 8'hff); wr(8'h03, 8'h01); check_regs("R3 nine");
        wr(8'h03, 8'hff); check_regs("R2 sixteen");
        // R4
        wr(8'h04, 8'hc7); wr(8'h0a, 8'h01); check_regs("R4 rate");
        // R5 R6 reads
        rd(8'h02, "R5 rd lo"); rd(8'h03, "R5 rd hi");
        rd(8'h04, "R5 rd div"); rd(8'h0a, "R5 rd base");
        rd(8'h05, "R6 unmapped 05"); rd(8'hff, "R6 unmapped ff"); rd(8'h00, "R6 unmapped 00");

        // R7 unknown header
        put(8'h82, 0); put(8'h01, 0); put(8'h02, 0); put(8'h55, 1); idle(2);
        check_regs("R7 bad header");
        // R12 immediately after discard
        wr(8'h04, 8'h13); check_regs("R12 after discard");
        // R8 short packets
        put(8'h80, 0); put(8'h01, 0); put(8'h04, 1); idle(2);
        put(8'h81, 0); put(8'h01, 1); idle(2);
        put(8'h80, 1); idle(2);
        check_regs("R8 short");
        // R9 long packets
        put(8'h80, 0); put(8'h01, 0); put(8'h04, 0); put(8'h11, 0); put(8'h22, 1); idle(2);
        put(8'h81, 0); put(8'h01, 0); put(8'h02, 0); put(8'h03, 1); idle(2);
        check_regs("R9 long");
        // R10 bad sub-code
        put(8'h80, 0); put(8'h02, 0); put(8'h04, 0); put(8'h33, 1); idle(2);
        put(8'h81, 0); put(8'h00, 0); put(8'h02, 1); idle(2);
        check_regs("R10 subcode");
        // R11 write unmapped
        wr(8'h05, 8'h77); check_regs("R11 unmapped write");
        rd(8'h05, "R11 unmapped readback");
        // R13 gaps within packets
        put(8'h80, 0); idle(3); put(8'h01, 0); idle(1); put(8'h0a, 0); idle(2); put(8'h5a, 1);
        m_base = 8'h5a; idle(1);
        check_regs("R13 gapped write");
        put(8'h81, 0); idle(2); put(8'h01, 0); idle(2); put(8'h0a, 1);
        exp_q.push_back(8'h5a); tag_q.push_back("R13 gapped read");
        idle(4);
        rd(8'h0a, "R12 read after all");

        idle(5);
        check("R5 pending responses", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule